// File: doc/BRIEF.md
# Programmable Serial Output Bit Mapper

This block sits between the conversion pipeline of a dual-channel converter and its serial output lanes. Each frame it takes four 20-bit words: the current and the previous sample of channel A and channel B. It builds the bit stream of each of four lanes (two per channel, called wire 0 and wire 1) from a table of 80 programmable slots, 40 per channel. Every slot holds a 7-bit source identifier. The identifier names one bit of one sample of one channel, so any bit can be placed in any serial position. The same mechanism can carry a redundant copy of a sample on a second lane, or put both channels on a single lane.

A lane-mode input selects two-wire, one-wire or half-wire operation. A resolution input selects 14, 16, 18 or 20 bits per sample. A simple write port loads the slot table through a shadow copy. The shadow copy moves into the active table only at a frame boundary, so a frame that is already running is never changed. The block sends one bit per lane per clock. A one-cycle frame-start pulse marks slot 0.

Top module: `serial_bit_mapper`

## Requirements
- R1: Identifier bit 6 selects the current sample (1) or the previous sample (0), and bit 2 selects channel A (1) or channel B (0). Bits 5:3 (g) and 1:0 (b) give the data bit 4g+b-2, which must lie in 0..19. This makes channel A current D19..D0 equal to 0x6D, 0x6C, 0x67-0x64, 0x5F-0x5C, 0x57-0x54, 0x4F-0x4C, 0x47, 0x46. Any identifier that does not decode to a data bit drives a 0.
- R2: `res_i` sets the resolution N = 14 + 2*res_i. Data bits below index 20-N drive 0.
- R3: Two-wire mode (`mode_i`=0) has a frame of N cycles. In cycle c, wire 0 of each channel sends slot c and wire 1 sends slot 20+c of that channel's table. Channel A uses table addresses 0..39 and channel B uses 40..79.
- R4: One-wire mode (`mode_i`=1, and also the reserved value 3) has a frame of N cycles. Wire 1 sends slot c. Wire 0 sends slot 20+c when the duplicate enable is set and is 0 when it is clear. Previous-sample identifiers drive 0 in every mode except two-wire.
- R5: Half-wire mode (`mode_i`=2) has a frame of 2N cycles. Only lane 1 (channel A, wire 1) is driven, from channel A slots 0..2N-1. The other three lanes stay 0.
- R6: `frame_start_o` is high exactly in slot-0 cycles, and consecutive frames follow with no gap.
- R7: A write to an address of 80 or above is ignored. A write to a lower address becomes visible from the first frame that starts after the write edge. A write never changes a frame that is in progress.
- R8: The samples, mode, resolution and duplicate enable are captured at the frame boundary. Changing them during a frame has no effect until the next frame.
- R9: While reset is asserted, all lanes and `frame_start_o` are 0 and the table is cleared. The first frame starts in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_a_i | input | 20 | Channel A current sample |
| prev_a_i | input | 20 | Channel A previous sample |
| cur_b_i | input | 20 | Channel B current sample |
| prev_b_i | input | 20 | Channel B previous sample |
| mode_i | input | 2 | Lane mode: 0 two-wire, 1 one-wire, 2 half-wire |
| res_i | input | 2 | Resolution select, N = 14 + 2*res_i |
| dup_en_i | input | 1 | Duplicate the one-wire stream on wire 0 |
| cfg_we_i | input | 1 | Slot table write strobe |
| cfg_addr_i | input | 7 | Slot address, 0..39 channel A, 40..79 channel B |
| cfg_data_i | input | 7 | Source identifier to store |
| lane_o | output | 4 | Lanes: [0] A wire 0, [1] A wire 1, [2] B wire 0, [3] B wire 1 |
| frame_start_o | output | 1 | High during the slot-0 cycle |

## Verification
A frame boundary is a clock edge. At that edge the block captures the inputs and the shadow table, and in the cycle that follows, `frame_start_o` and the slot-0 bits are already valid; slot c appears c cycles later. A table write takes effect at the first boundary edge after its own write edge, so a write made in the last cycle of a frame still misses the next frame. The bench snapshots its own shadow model and the driven inputs when it sees the frame-start pulse, before it applies any change made at that edge. It then compares one queued lane vector at every falling edge, so a lag of even one cycle, a frame of the wrong length or a change in mid-frame shows up as a mismatch.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int SMP_W   = 20;
  localparam int ID_W    = 7;
  localparam int SLOTS   = 40;
  localparam int LANES   = 4;
  localparam int MIN_RES = SMP_W - 6;
  localparam int CNT_W   = $clog2(2 * SMP_W);
  localparam int NB_W    = $clog2(SMP_W + 1);
  localparam int TAB_N   = 2 * SLOTS;
  localparam int AW      = $clog2(TAB_N);

  typedef enum logic [1:0] {
    MODE_2W   = 2'd0,
    MODE_1W   = 2'd1,
    MODE_HALF = 2'd2,
    MODE_RSV  = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic       ok;
    logic       cur;
    logic       cha;
    logic [4:0] idx;
  } src_t;

  // Identifier layout: [6] current/previous, [5:3] group, [2] channel, [1:0] sub-bit
  function automatic src_t decode_id(input logic [ID_W-1:0] id);
    src_t       s;
    logic [5:0] raw;
    raw   = {1'b0, id[5:3], 2'b00} + {4'b0000, id[1:0]};
    s.ok  = (raw >= 6'd2) && (raw <= 6'd21);
    s.idx = 5'(raw - 6'd2);
    s.cur = id[6];
    s.cha = id[2];
    return s;
  endfunction
endpackage

// File: rtl/sbm_bit_pick.sv
module sbm_bit_pick
  import sbm_pkg::*;
(
  input  logic             en_i,
  input  logic             prev_ok_i,
  input  logic [NB_W-1:0]  lsb_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [SMP_W-1:0] cur_a_i,
  input  logic [SMP_W-1:0] prev_a_i,
  input  logic [SMP_W-1:0] cur_b_i,
  input  logic [SMP_W-1:0] prev_b_i,
  output logic             bit_o
);
  src_t             src;
  logic [SMP_W-1:0] word;

  always_comb begin
    src = decode_id(id_i);
    if (src.cur) word = src.cha ? cur_a_i : cur_b_i;
    else         word = src.cha ? prev_a_i : prev_b_i;
    bit_o = en_i && src.ok && (src.cur || prev_ok_i)
            && ({1'b0, src.idx} >= {{(6-NB_W){1'b0}}, lsb_i})
            && word[src.idx];
  end
endmodule

// File: rtl/sbm_frame_seq.sv
module sbm_frame_seq
  import sbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lane_mode_e       mode_i,
  input  logic [1:0]       res_i,
  input  logic             dup_i,
  output logic             run_o,
  output logic             load_o,
  output logic [CNT_W-1:0] cnt_o,
  output lane_mode_e       mode_o,
  output logic [NB_W-1:0]  nbits_o,
  output logic             dup_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_in;
  logic [NB_W-1:0]  nb_q, nb_in;
  lane_mode_e       mode_q;
  logic             dup_q;
  logic             load;

  always_comb begin
    nb_in  = NB_W'(MIN_RES) + NB_W'({res_i, 1'b0});
    len_in = (mode_i == MODE_HALF) ? CNT_W'({nb_in, 1'b0}) : CNT_W'(nb_in);
    load   = !run_q || (cnt_q == len_q - 1'b1);
    cnt_d  = load ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      nb_q   <= '0;
      mode_q <= MODE_2W;
      dup_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      cnt_q <= cnt_d;
      if (load) begin
        len_q  <= len_in;
        nb_q   <= nb_in;
        mode_q <= mode_i;
        dup_q  <= dup_i;
      end
    end
  end

  assign run_o   = run_q;
  assign load_o  = load;
  assign cnt_o   = cnt_q;
  assign mode_o  = mode_q;
  assign nbits_o = nb_q;
  assign dup_o   = dup_q;

  // R6: the slot counter stays inside the captured frame length
  a_r6_cnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < len_q));
  // R6: no slot skipped inside a frame
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sbm_slot_table.sv
module sbm_slot_table
  import sbm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ID_W-1:0]            wr_addr_i,
  input  logic [ID_W-1:0]            wr_data_i,
  input  logic                       commit_i,
  input  logic [LANES-1:0][AW-1:0]   rd_idx_i,
  output logic [LANES-1:0][ID_W-1:0] rd_id_o
);
  logic [TAB_N-1:0][ID_W-1:0] shadow_q, shadow_d, active_q;
  logic                       wr_hit;

  always_comb begin
    wr_hit   = wr_en_i && (32'(wr_addr_i) < TAB_N);
    shadow_d = shadow_q;
    if (wr_hit) shadow_d[AW'(wr_addr_i)] = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_hit)   shadow_q <= shadow_d;
      if (commit_i) active_q <= shadow_q;
    end
  end

  for (genvar r = 0; r < LANES; r++) begin : g_rd
    assign rd_id_o[r] = active_q[rd_idx_i[r]];
  end

  // R7: the active table only changes on a frame boundary
  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(active_q));
  // R7: a boundary copies the shadow as it stood before that edge
  a_r7_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/serial_bit_mapper.sv
module serial_bit_mapper
  import sbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] cur_a_i,
  input  logic [19:0] prev_a_i,
  input  logic [19:0] cur_b_i,
  input  logic [19:0] prev_b_i,
  input  logic [1:0]  mode_i,
  input  logic [1:0]  res_i,
  input  logic        dup_en_i,
  input  logic        cfg_we_i,
  input  logic [6:0]  cfg_addr_i,
  input  logic [6:0]  cfg_data_i,
  output logic [3:0]  lane_o,
  output logic        frame_start_o
);
  localparam logic [CNT_W-1:0] HALF_OFF = CNT_W'(SLOTS / 2);

  logic                       run, load, dup_q;
  logic [CNT_W-1:0]           cnt;
  lane_mode_e                 mode_q;
  logic [NB_W-1:0]            nb_q, lsb;
  logic [SMP_W-1:0]           ca_q, pa_q, cb_q, pb_q;
  logic [LANES-1:0][AW-1:0]   rd_idx;
  logic [LANES-1:0][ID_W-1:0] rd_id;
  logic [LANES-1:0]           lane_bits;

  sbm_frame_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (lane_mode_e'(mode_i)),
    .res_i   (res_i),
    .dup_i   (dup_en_i),
    .run_o   (run),
    .load_o  (load),
    .cnt_o   (cnt),
    .mode_o  (mode_q),
    .nbits_o (nb_q),
    .dup_o   (dup_q)
  );

  sbm_slot_table u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_we_i),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (cfg_data_i),
    .commit_i  (load),
    .rd_idx_i  (rd_idx),
    .rd_id_o   (rd_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      pa_q <= '0;
      cb_q <= '0;
      pb_q <= '0;
    end else if (load) begin
      ca_q <= cur_a_i;
      pa_q <= prev_a_i;
      cb_q <= cur_b_i;
      pb_q <= prev_b_i;
    end
  end

  assign lsb = NB_W'(SMP_W) - nb_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int CH = l / 2;
    localparam bit W1 = (l % 2) == 1;
    logic [CNT_W-1:0] off;
    logic             en;

    always_comb begin
      off = cnt;
      en  = run;
      case (mode_q)
        MODE_2W:   off = W1 ? cnt + HALF_OFF : cnt;
        MODE_HALF: en  = run && (l == 1);
        default: begin
          off = W1 ? cnt : cnt + HALF_OFF;
          en  = run && (W1 || dup_q);
        end
      endcase
    end

    assign rd_idx[l] = AW'(CH * SLOTS) + AW'(off);

    sbm_bit_pick u_pick (
      .en_i      (en),
      .prev_ok_i (mode_q == MODE_2W),
      .lsb_i     (lsb),
      .id_i      (rd_id[l]),
      .cur_a_i   (ca_q),
      .prev_a_i  (pa_q),
      .cur_b_i   (cb_q),
      .prev_b_i  (pb_q),
      .bit_o     (lane_bits[l])
    );
  end

  assign lane_o        = lane_bits;
  assign frame_start_o = run && (cnt == '0);

  // R5: half-wire drives a single lane
  a_r5_half_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_HALF) |-> (lane_o[0] == 1'b0 && lane_o[3:2] == 2'b00));
  // R4: without duplication wire 0 stays quiet in one-wire mode
  a_r4_no_dup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dup_q && (mode_q == MODE_1W || mode_q == MODE_RSV)) |-> (lane_o[0] == 1'b0 && lane_o[2] == 1'b0));
  // R6: frame start is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);
  // R9: the first active cycle after reset is a frame start
  a_r9_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> frame_start_o);
endmodule

// File: tb/serial_bit_mapper_test.sv
`timescale 1ns/1ps
module serial_bit_mapper_test;
  logic        clk;
  logic        rst_n;
  logic [19:0] cur_a, prev_a, cur_b, prev_b;
  logic [1:0]  mode, res;
  logic        dup_en, cfg_we;
  logic [6:0]  cfg_addr, cfg_data;
  logic [3:0]  lane_o;
  logic        frame_start;

  serial_bit_mapper uut (
    .clk (clk), .rst_n (rst_n),
    .cur_a_i (cur_a), .prev_a_i (prev_a), .cur_b_i (cur_b), .prev_b_i (prev_b),
    .mode_i (mode), .res_i (res), .dup_en_i (dup_en),
    .cfg_we_i (cfg_we), .cfg_addr_i (cfg_addr), .cfg_data_i (cfg_data),
    .lane_o (lane_o), .frame_start_o (frame_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  int    nframes = 0;
  string tag = "R9";
  int    bshadow[80];
  int    s_tab[80];
  logic [19:0] s_ca, s_pa, s_cb, s_pb;
  int    s_mode, s_nb;
  bit    s_dup;
  logic [4:0] exp_q[$];
  // channel A current-sample identifiers, D19 first (R1)
  int acur[20] = '{'h6D, 'h6C, 'h67, 'h66, 'h65, 'h64, 'h5F, 'h5E, 'h5D, 'h5C,
                   'h57, 'h56, 'h55, 'h54, 'h4F, 'h4E, 'h4D, 'h4C, 'h47, 'h46};

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(int id);
    for (int d = 0; d < 20; d++) begin
      int bi = 19 - d;
      if (bi < 20 - s_nb) continue;            // R2
      if (id == acur[d])          return s_ca[bi];
      if (id == acur[d] - 'h40)   return (s_mode == 0) ? s_pa[bi] : 1'b0;
      if (id == acur[d] - 4)      return s_cb[bi];
      if (id == acur[d] - 'h44)   return (s_mode == 0) ? s_pb[bi] : 1'b0;
    end
    return 1'b0;
  endfunction

  // driver side: queue the expected lane vectors of one frame
  task automatic push_frame();
    int len = (s_mode == 2) ? 2 * s_nb : s_nb;
    for (int c = 0; c < len; c++) begin
      logic [3:0] ln;
      for (int l = 0; l < 4; l++) begin
        int ch = l / 2;
        int w = l % 2;
        int slot;
        bit en;
        if (s_mode == 0) begin en = 1; slot = w ? 20 + c : c; end        // R3
        else if (s_mode == 2) begin en = (l == 1); slot = c; end         // R5
        else begin en = (w == 1) || s_dup; slot = w ? c : 20 + c; end    // R4
        ln[l] = en ? exp_bit(s_tab[ch * 40 + slot]) : 1'b0;
      end
      exp_q.push_back({c == 0, ln});
    end
  endtask

  // monitor side: one falling edge, compare, then track committed writes (R7)
  task automatic step();
    logic [4:0] e;
    @(negedge clk);
    if (rst_n) begin
      if (frame_start) begin
        check(exp_q.size() == 0, "frame length R6", exp_q.size(), 0);
        exp_q.delete();
        s_tab = bshadow;
        s_ca = cur_a; s_pa = prev_a; s_cb = cur_b; s_pb = prev_b;
        s_mode = mode; s_nb = 14 + 2 * res; s_dup = dup_en;
        push_frame();
        nframes++;
      end
      if (exp_q.size() == 0) check(1'b0, "frame start missing R6", 0, 1);
      else begin
        e = exp_q.pop_front();
        check({frame_start, lane_o} == e, "lanes {start,lane}", {frame_start, lane_o}, e);
      end
    end
    if (cfg_we && cfg_addr < 80) bshadow[cfg_addr] = cfg_data;
  endtask

  task automatic new_samples();
    cur_a = 20'($urandom); prev_a = 20'($urandom);
    cur_b = 20'($urandom); prev_b = 20'($urandom);
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 7'(a); cfg_data = 7'(d);
    step();
    cfg_we = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      step();
      if (i % 7 == 3) new_samples();   // R8: mid-frame changes
    end
  endtask

  initial begin
    for (int i = 0; i < 80; i++) bshadow[i] = 0;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_data = 0;
    mode = 0; res = 3; dup_en = 0;
    new_samples();
    repeat (3) begin
      @(negedge clk);
      check(lane_o == 0 && frame_start == 0, "reset outputs R9", {frame_start, lane_o}, 0);
    end
    rst_n = 1;
    step();
    check(nframes == 1, "first frame right after reset R9", nframes, 1);

    tag = "R3 two-wire identity";
    for (int k = 0; k < 20; k++) begin
      wr(k, acur[k]);            wr(20 + k, acur[k] - 'h40);
      wr(40 + k, acur[k] - 4);   wr(60 + k, acur[k] - 'h44);
    end
    run(70);

    tag = "R2 14-bit truncation";
    res = 0;
    for (int k = 0; k < 20; k++) wr(40 + k, acur[19 - k] - 4);
    run(60);

    tag = "R4 one-wire no duplicate";
    mode = 1; res = 1;
    for (int k = 0; k < 4; k++) wr(k, acur[k] - 'h40);
    run(50);
    tag = "R4 one-wire duplicate";
    dup_en = 1;
    run(50);

    tag = "R5 half-wire merge";
    mode = 2; res = 2;
    for (int k = 0; k < 18; k++) begin wr(k, acur[k]); wr(18 + k, acur[k] - 4); end
    run(120);

    tag = "R1 free identifiers";
    for (int i = 0; i < 80; i++) wr(i, int'(7'($urandom)));
    for (int m = 0; m < 3; m++) begin mode = 2'(m); res = 2'(3 - m); run(90); end

    tag = "R7 late and stray writes";
    mode = 0; res = 3;
    run(5);
    wr(90, 'h6D); wr(127, 'h6C);
    for (int i = 0; i < 20; i++) wr(i, acur[19 - i]);
    run(60);

    tag = "R8 mid-frame input change";
    mode = 1; dup_en = 0; res = 0;
    run(7);
    mode = 0; res = 3; new_samples();
    run(60);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule